// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational 32-bit unsigned adder. It takes two operands and a carry-in, and returns a 32-bit sum and a carry-out. There is no clock and no state. The operand width is split into six segments that get wider toward the top: bits 3..0, 8..4, 14..9, 21..15, 29..22 and 31..30. Each segment's precomputed result is ready at about the time the carry that selects it arrives, so the total delay grows roughly with the square root of the width rather than linearly.

The lowest segment is a single ripple chain fed straight from the external carry-in. Every higher segment holds two ripple chains. One is fed a fixed carry of 0 and the other a fixed carry of 1. A 2:1 multiplexer picks that segment's sum bits and its carry-out, steered by the selected carry coming out of the segment just below. The carry-out of the top segment is the carry-out of the adder.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum_o` equals (`a_in` + `b_in` + `cin`) mod 2^32 for every input combination.
- R2: `cout` equals bit 32 of the full-width result `a_in` + `b_in` + `cin`.
- R3: With `a_in` = 0xFFFFFFFF, `b_in` = 0 and `cin` = 1, the carry travels through every segment, giving `sum_o` = 0 and `cout` = 1. With both operands at 0xFFFFFFFF and `cin` = 1, the result is `sum_o` = 0xFFFFFFFF and `cout` = 1.
- R4: The segment boundaries sit above bits 3, 8, 14, 21 and 29. A carry produced at the top bit of any segment appears at the lowest bit of the next segment. For example, adding 1<<p to itself gives 1<<(p+1).
- R5: In every segment above the lowest, the {carry, sum} candidate built with carry 1 equals the candidate built with carry 0 plus one.
- R6: The lowest segment uses `cin` directly. With both operands 0 and `cin` = 1, `sum_o` = 1 and `cout` = 0.
- R7: The outputs depend only on the current inputs, with no clock. A change of inputs shows up at the outputs within the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum modulo 2^32 |
| cout | output | 1 | Carry out of bit 31 |

## Verification
Random operands almost never drive the select carry across several segments at once, so those long paths are rarely exercised. The hardest case is a carry born in the lowest segment that must flip the multiplexer choice in every segment above it. The stimulus reaches it on purpose: it sets up all-propagate operands with a carry-in of 1, then places a generated carry at the top bit of each segment in turn. Random operands with random carry-in are mixed in to cover the general case.

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder (
  input  logic [31:0] a_in,
  input  logic [31:0] b_in,
  input  logic        cin,
  output logic [31:0] sum_o,
  output logic        cout
);
  localparam int WIDTH = 32;
  localparam int NSEG  = 6;
  localparam int BASEW = 4;

  function automatic int seg_lo(input int k);
    int lo;
    lo = 0;
    for (int j = 0; j < k; j++) lo += BASEW + j;
    return lo;
  endfunction

  function automatic int seg_w(input int k);
    return (k < NSEG - 1) ? BASEW + k : WIDTH - seg_lo(k);
  endfunction

  logic [NSEG:0] selc;
  assign selc[0] = cin;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int LO = seg_lo(k);
    localparam int W  = seg_w(k);
    logic [W-1:0] sa, sb;
    assign sa = a_in[LO +: W];
    assign sb = b_in[LO +: W];

    if (k == 0) begin : g_low
      logic [W:0]   c;
      logic [W-1:0] s;
      assign c[0] = selc[0];
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = sa[i] ^ sb[i] ^ c[i];
        assign c[i+1] = (sa[i] & sb[i]) | (c[i] & (sa[i] ^ sb[i]));
      end
      assign sum_o[LO +: W] = s;
      assign selc[k+1]      = c[W];
    end else begin : g_sel
      logic [W:0]   c0, c1;
      logic [W-1:0] s0, s1;
      assign c0[0] = 1'b0;
      assign c1[0] = 1'b1;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign s0[i]   = sa[i] ^ sb[i] ^ c0[i];
        assign c0[i+1] = (sa[i] & sb[i]) | (c0[i] & (sa[i] ^ sb[i]));
        assign s1[i]   = sa[i] ^ sb[i] ^ c1[i];
        assign c1[i+1] = (sa[i] & sb[i]) | (c1[i] & (sa[i] ^ sb[i]));
      end
      assign sum_o[LO +: W] = selc[k] ? s1 : s0;
      assign selc[k+1]      = selc[k] ? c1[W] : c0[W];

      always_comb begin
        a_r5_cand_step: assert ({c1[W], s1} == ({c0[W], s0} + 1'b1))
          else $error("R5 candidate mismatch in segment %0d", k);
        a_r5_carry_order: assert (c1[W] | ~c0[W])
          else $error("R5 carry order in segment %0d", k);
      end
    end
  end

  assign cout = selc[NSEG];

  always_comb begin
    a_r1_r2_total: assert ({cout, sum_o} == ({1'b0, a_in} + {1'b0, b_in} + {32'd0, cin}))
      else $error("R1/R2 result mismatch");
    a_r6_low_cin: assert (sum_o[0] == (a_in[0] ^ b_in[0] ^ cin))
      else $error("R6 bit0 mismatch");
  end
endmodule

// File: tb/sqrt_csel_adder_test.sv
module sqrt_csel_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a, b, s;
  logic        ci, co;
  int total = 0, bad = 0;
  bit done = 1'b0;

  sqrt_csel_adder uut (.a_in(a), .b_in(b), .cin(ci), .sum_o(s), .cout(co));

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] y, input logic c);
    longint unsigned r;
    @(posedge clk);
    a = x; b = y; ci = c;
    r = longint'(x) + longint'(y) + longint'(c);
    @(negedge clk);
    check(tag, {co, s}, r[32:0]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bnd[5] = '{3, 8, 14, 21, 29};
    a = 0; b = 0; ci = 0;
    apply("R1 zero", 32'd0, 32'd0, 1'b0);
    apply("R6 cin only", 32'd0, 32'd0, 1'b1);
    check("R6 literal", {co, s}, 33'd1);
    apply("R3 full propagate", 32'hFFFF_FFFF, 32'd0, 1'b1);
    check("R3 literal", {co, s}, 33'h1_0000_0000);
    apply("R3 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check("R3 all ones literal", {co, s}, {1'b1, 32'hFFFF_FFFF});
    apply("R2 top carry", 32'h8000_0000, 32'h8000_0000, 1'b0);
    foreach (bnd[i]) begin
      apply("R4 boundary gen", 32'd1 << bnd[i], 32'd1 << bnd[i], 1'b0);
      check("R4 boundary literal", {co, s}, {1'b0, 32'd1 << (bnd[i] + 1)});
      apply("R4 boundary prop", (32'd1 << (bnd[i] + 1)) - 1, 32'd0, 1'b1);
    end
    apply("R5 alternating", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    @(posedge clk);
    #1 a = 32'h0000_FFFF; b = 32'h0000_0001; ci = 1'b0;
    #0.5 check("R7 same step", {co, s}, 33'h0_0001_0000);
    for (int n = 0; n < 2000; n++)
      apply("R1 R2 random", $urandom, $urandom, 1'($urandom));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule